// File: doc/BRIEF.md
# Cascadable Column-Driver Data Loader

This block is the digital input stage of a display column driver that can be chained with identical parts. A start pulse arms a one-hot write pointer. From then on, every clock edge captures one input word into the next slot of a line-wide data register. A word holds six gray codes of six bits each. The pointer walks the slots either upward from output 0 or downward from the last output.

Near the end of its walk the pointer sends a one-cycle start pulse out of the opposite end of the chip, so the next driver in the chain takes over the following words with no gap. A little later the pointer goes idle by itself, and no more data is taken until the next start pulse.

Once per line, a rising edge on the strobe copies the whole data register into the output latch and disarms the pointer. The latch feeds the converters that follow this block. An inversion input can complement the gray codes as they are captured.

Top module: `col_loader`

## Requirements
- R1: The clock edge that samples the active start input high stores word 0. Each following edge stores the next word, up to word 63. Code i of a word occupies word bits [6i+5:6i], with bit 6i as the LSB. In ascending mode, code i of word j goes to output 6j+i, which is bits [6(6j+i)+5 : 6(6j+i)] of `level_out`.
- R2: With `ascend` high, `sp_low_in` is the start input and `sp_high_out` is the carry output. With `ascend` low, `sp_high_in` is the start input, `sp_low_out` is the carry output, and word j fills slot 63-j, that is outputs 6(63-j)+i. The start input that is not selected is ignored, and the carry output that is not selected stays low.
- R3: The selected carry output is high for exactly one cycle, after the 64th edge, counting the start edge as the first. It is low at all other times.
- R4: After the 64th edge the pointer accepts no more words. Later edges, and edges while the pointer is idle, leave the data register unchanged until a new start pulse arrives.
- R5: On a clock edge where `strobe` is sampled high after being low, the output latch takes the data register contents from before that edge. The same edge clears the pointer and the carry, and no word is captured on it. Clocks after that edge store nothing until a new start pulse arrives.
- R6: When `invert` is high at a capture edge, each stored code is the bitwise complement of the input code. When `invert` is low, the code is stored unchanged.
- R7: The output latch changes only on a strobe rising edge. A strobe held high does not transfer again.
- R8: Asserting `rst_n` low clears the output latch, the pointer and the carry outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift and capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ascend | input | 1 | 1: fill from output 0 upward; 0: fill from the last output downward |
| sp_low_in | input | 1 | Start pulse input at the output-0 end (used when ascending) |
| sp_high_in | input | 1 | Start pulse input at the last-output end (used when descending) |
| sp_low_out | output | 1 | Carry start pulse at the output-0 end (driven when descending) |
| sp_high_out | output | 1 | Carry start pulse at the last-output end (driven when ascending) |
| strobe | input | 1 | Line strobe; its rising edge transfers the register to the latch |
| invert | input | 1 | Complement incoming gray codes |
| word_in | input | 36 | Six 6-bit gray codes |
| level_out | output | 2304 | Latched 6-bit code for each of the 384 outputs |

## Verification
The checks assume that the strobe and a start pulse never rise in the same cycle. They also assume that `ascend` does not change while a line is being loaded. The bench therefore drives `ascend` and `invert` only in the cycle before a start edge. It starts each line only after the previous strobe has fallen again. The assertion on one-cycle carry pulses further assumes that no new start pulse arrives while a walk is still in progress. The bench pulses only the ignored start pin in the middle of a line.

// File: rtl/cdl_pkg.sv
package cdl_pkg;

  typedef enum logic {
    FILL_DOWN = 1'b0,
    FILL_UP   = 1'b1
  } fill_dir_e;

  // Complement every code of a captured word when inversion is requested.
  function automatic logic [35:0] apply_invert(input logic [35:0] w, input logic inv);
    return inv ? ~w : w;
  endfunction

endpackage

// File: rtl/cdl_pointer.sv
module cdl_pointer #(
  parameter int SLOTS = 64,
  parameter int TAIL  = 2,
  localparam int PW   = SLOTS + TAIL - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ascend,
  input  logic             sp_low_in,
  input  logic             sp_high_in,
  input  logic             strobe,
  output logic [SLOTS-1:0] wr_en,
  output logic             carry,
  output logic             strobe_rise,
  output logic [PW-1:0]    ptr_state
);

  logic [PW-1:0] ptr_q, ptr_d;
  logic          carry_q, carry_d;
  logic          strobe_q;
  logic          start_sel;

  assign start_sel   = (ascend == cdl_pkg::FILL_UP) ? sp_low_in : sp_high_in;
  assign strobe_rise = strobe & ~strobe_q;

  // Next state: the strobe edge wins, a start re-arms, otherwise the token walks.
  always_comb begin
    if (strobe_rise) begin
      ptr_d   = '0;
      carry_d = 1'b0;
    end else begin
      if (start_sel) ptr_d = PW'(1);
      else           ptr_d = ptr_q << 1;
      carry_d = ptr_q[SLOTS-2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      carry_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      ptr_q    <= ptr_d;
      carry_q  <= carry_d;
      strobe_q <= strobe;
    end
  end

  // Write enables, in logical fill order.
  for (genvar j = 0; j < SLOTS; j++) begin : g_wen
    if (j == 0) begin : g_first
      assign wr_en[j] = start_sel & ~strobe_rise;
    end else begin : g_rest
      assign wr_en[j] = ptr_q[j-1] & ~start_sel & ~strobe_rise;
    end
  end

  assign carry     = carry_q;
  assign ptr_state = ptr_q;

endmodule

// File: rtl/cdl_capture.sv
module cdl_capture #(
  parameter int SLOTS  = 64,
  parameter int WORD_W = 36,
  localparam int REG_W = SLOTS * WORD_W
) (
  input  logic              clk,
  input  logic              ascend,
  input  logic              invert,
  input  logic [SLOTS-1:0]  wr_en,
  input  logic [WORD_W-1:0] word_in,
  output logic [REG_W-1:0]  data_q
);

  logic [WORD_W-1:0] word_eff;

  assign word_eff = cdl_pkg::apply_invert(word_in, invert);

  // One physical slot per block; the logical enable is mirrored when descending.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              en_s;
    logic [WORD_W-1:0] q;

    assign en_s = (ascend == cdl_pkg::FILL_UP) ? wr_en[s] : wr_en[SLOTS-1-s];

    always_ff @(posedge clk) begin
      if (en_s) q <= word_eff;
    end

    assign data_q[s*WORD_W +: WORD_W] = q;
  end

endmodule

// File: rtl/cdl_latch.sv
module cdl_latch #(
  parameter int W = 2304
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/col_loader.sv
module col_loader #(
  parameter int NUM_OUT        = 384,
  parameter int CODE_W         = 6,
  parameter int CODES_PER_WORD = 6,
  localparam int WORD_W = CODE_W * CODES_PER_WORD,
  localparam int SLOTS  = NUM_OUT / CODES_PER_WORD,
  localparam int LINE_W = NUM_OUT * CODE_W,
  localparam int TAIL   = 2,
  localparam int PW     = SLOTS + TAIL - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ascend,
  input  logic              sp_low_in,
  input  logic              sp_high_in,
  output logic              sp_low_out,
  output logic              sp_high_out,
  input  logic              strobe,
  input  logic              invert,
  input  logic [WORD_W-1:0] word_in,
  output logic [LINE_W-1:0] level_out
);

  logic [SLOTS-1:0]  wr_en;
  logic              carry;
  logic              strobe_rise;
  logic [PW-1:0]     ptr_state;
  logic [LINE_W-1:0] data_q;

  cdl_pointer #(.SLOTS(SLOTS), .TAIL(TAIL)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ascend     (ascend),
    .sp_low_in  (sp_low_in),
    .sp_high_in (sp_high_in),
    .strobe     (strobe),
    .wr_en      (wr_en),
    .carry      (carry),
    .strobe_rise(strobe_rise),
    .ptr_state  (ptr_state)
  );

  cdl_capture #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_cap (
    .clk    (clk),
    .ascend (ascend),
    .invert (invert),
    .wr_en  (wr_en),
    .word_in(word_in),
    .data_q (data_q)
  );

  cdl_latch #(.W(LINE_W)) u_lat (
    .clk  (clk),
    .rst_n(rst_n),
    .load (strobe_rise),
    .d    (data_q),
    .q    (level_out)
  );

  // The carry leaves at the end opposite to the selected start input.
  assign sp_high_out = ascend & carry;
  assign sp_low_out  = ~ascend & carry;

endmodule

// File: rtl/col_loader_chk.sv
module col_loader_chk #(
  parameter int SLOTS  = 64,
  parameter int PW     = 65,
  parameter int LINE_W = 2304
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sp_low_in,
  input logic              sp_high_in,
  input logic              sp_low_out,
  input logic              sp_high_out,
  input logic              strobe_rise,
  input logic [PW-1:0]     ptr_state,
  input logic [LINE_W-1:0] data_q,
  input logic [LINE_W-1:0] level_out
);

  // R2
  carry_pins_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sp_low_out && sp_high_out));

  // R3
  carry_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_low_out || sp_high_out) |=> !(sp_low_out || sp_high_out));

  // R4
  idle_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_state == '0 && !sp_low_in && !sp_high_in) |=> $stable(data_q));

  // R5
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> (level_out == $past(data_q)));

  // R5
  strobe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> (ptr_state == '0 && !sp_low_out && !sp_high_out));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_rise |=> $stable(level_out));

endmodule

bind col_loader col_loader_chk #(.SLOTS(SLOTS), .PW(PW), .LINE_W(LINE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sp_low_in  (sp_low_in),
  .sp_high_in (sp_high_in),
  .sp_low_out (sp_low_out),
  .sp_high_out(sp_high_out),
  .strobe_rise(strobe_rise),
  .ptr_state  (ptr_state),
  .data_q     (data_q),
  .level_out  (level_out)
);

// File: tb/test_col_loader.sv
module test_col_loader;
  localparam int NUM_OUT = 384;
  localparam int CODE_W  = 6;
  localparam int CPW     = 6;
  localparam int WORD_W  = CODE_W * CPW;
  localparam int SLOTS   = NUM_OUT / CPW;
  localparam int LINE_W  = NUM_OUT * CODE_W;

  // {ascend, invert, seed}
  localparam logic [7:0] VEC [4] = '{
    {1'b1, 1'b0, 6'd5},
    {1'b0, 1'b0, 6'd17},
    {1'b1, 1'b1, 6'd33},
    {1'b0, 1'b1, 6'd50}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ascend, sp_low_in, sp_high_in, strobe, invert;
  logic [WORD_W-1:0] word_in;
  logic              sp_low_out, sp_high_out;
  logic [LINE_W-1:0] level_out;

  int checks   = 0;
  int failures = 0;
  logic [CODE_W-1:0] model     [NUM_OUT];
  logic [CODE_W-1:0] model_lat [NUM_OUT];

  always #4 clk = ~clk;

  col_loader i_col_loader (
    .clk(clk), .rst_n(rst_n), .ascend(ascend),
    .sp_low_in(sp_low_in), .sp_high_in(sp_high_in),
    .sp_low_out(sp_low_out), .sp_high_out(sp_high_out),
    .strobe(strobe), .invert(invert), .word_in(word_in),
    .level_out(level_out)
  );

  function automatic logic [WORD_W-1:0] gen(int seed, int j);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < CPW; i++) w[i*CODE_W +: CODE_W] = 6'((seed * 7 + j * 5 + i * 11) % 64);
    return w;
  endfunction

  task automatic store(bit asc, bit inv, int j, logic [WORD_W-1:0] w);
    int s;
    s = asc ? j : SLOTS - 1 - j;
    for (int i = 0; i < CPW; i++)
      model[s*CPW + i] = inv ? ~w[i*CODE_W +: CODE_W] : w[i*CODE_W +: CODE_W];
  endtask

  task automatic check_latch(string tag);
    int bad;
    bad = -1;
    for (int m = 0; m < NUM_OUT; m++)
      if (bad < 0 && level_out[m*CODE_W +: CODE_W] !== model_lat[m]) bad = m;
    checks++;
    if (bad >= 0) begin
      failures++;
      $display("FAIL %s: output %0d actual %0d expected %0d", tag, bad,
               level_out[bad*CODE_W +: CODE_W], model_lat[bad]);
    end
  endtask

  task automatic check_count(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_strobe();
    @(negedge clk);
    strobe = 1'b1;
    sp_low_in = 1'b0;
    sp_high_in = 1'b0;
    word_in = gen(77, 1);
    model_lat = model;
    @(negedge clk);
    @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_line(bit asc, bit inv, int seed, string tag, bit hold_check);
    int carry_bad, idle_bad;
    logic c_on, c_off;
    carry_bad = 0;
    idle_bad  = 0;
    for (int k = 0; k < SLOTS + 6; k++) begin
      @(negedge clk);
      if (k > 0) begin
        c_on  = asc ? sp_high_out : sp_low_out;
        c_off = asc ? sp_low_out : sp_high_out;
        if (c_on !== (k == SLOTS)) carry_bad++;
        if (c_off !== 1'b0) idle_bad++;
      end
      ascend = asc;
      invert = inv;
      if (asc) begin
        sp_low_in  = (k == 0);
        sp_high_in = (k == 20);
      end else begin
        sp_high_in = (k == 0);
        sp_low_in  = (k == 20);
      end
      if (k < SLOTS) begin
        word_in = gen(seed, k);
        store(asc, inv, k, word_in);
      end else begin
        word_in = gen(seed + 91, k);
      end
      if (hold_check && k == 32) check_latch("R7 latch held while loading");
    end
    check_count("R3 carry pulse timing, mismatching cycles", carry_bad, 0);
    check_count("R2 unselected carry pin high cycles", idle_bad, 0);
    do_strobe();
    check_latch(tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int cbad;
    rst_n = 1'b0; ascend = 1'b1; sp_low_in = 1'b0; sp_high_in = 1'b0;
    strobe = 1'b0; invert = 1'b0; word_in = '0;
    for (int m = 0; m < NUM_OUT; m++) begin model[m] = '0; model_lat[m] = '0; end
    repeat (3) @(negedge clk);
    check_latch("R8 reset clears latch");
    check_count("R8 carry outputs after reset", int'(sp_low_out) + int'(sp_high_out), 0);
    rst_n = 1'b1;

    for (int v = 0; v < 4; v++) begin
      string tag;
      if (v == 0)      tag = "R1 ascending fill";
      else if (v == 1) tag = "R2 descending fill";
      else if (v == 2) tag = "R6 inverted ascending fill";
      else             tag = "R6 inverted descending fill";
      run_line(VEC[v][7], VEC[v][6], int'(VEC[v][5:0]), tag, v > 0);
    end

    // R4: idle clocks with changing data must not alter the register
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      word_in = gen(63, k);
    end
    do_strobe();
    check_latch("R4 idle clocks leave data register");

    // R5: strobe in mid-line transfers partial data and disarms the pointer
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      ascend = 1'b1; invert = 1'b0;
      sp_low_in = (k == 0);
      word_in = gen(40, k);
      store(1'b1, 1'b0, k, word_in);
    end
    @(negedge clk);
    sp_low_in = 1'b0;
    strobe = 1'b1;
    word_in = gen(44, 3);
    model_lat = model;
    @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    check_latch("R5 strobe transfers partial line");
    cbad = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (sp_low_out !== 1'b0 || sp_high_out !== 1'b0) cbad++;
      word_in = gen(41, k);
    end
    check_count("R5 carry after strobe cleared pointer", cbad, 0);
    do_strobe();
    check_latch("R5 no capture after strobe cleared pointer");

    // R8: reset in operation
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    for (int m = 0; m < NUM_OUT; m++) model_lat[m] = '0;
    check_latch("R8 reset clears latch in operation");
    check_count("R8 carry outputs in reset", int'(sp_low_out) + int'(sp_high_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end

endmodule